// File: doc/BRIEF.md
# Embedded-Operation Status Word Generator

This block forms the byte a host sees when it reads a flash array while an embedded program or erase is running, or while an erase is suspended. A controller elsewhere supplies the operation kind, the run, timeout, accept-window and suspend flags, the suspended sector number and the data bit 7 being programmed. The host's read strobe and address arrive on the same clock. The block returns either a status byte or the array data that the array supplies, and it drives a ready line.

Two bits of the status byte are polarity flags: each flips on the rising edge of the read strobe. Two successive reads of a busy part therefore differ in those bits, and two reads of a finished part do not. Which flag moves depends on the kind of operation, on whether an erase is suspended, and on whether the read address lies inside the suspended sector. The sector number of an address is taken from its top `SECT_W` bits.

Top module: `status_word_gen`

## Requirements
- R1: When a program is running or has timed out (`op_erase`=0 with `busy` or `tmo_fail` high), bit 7 of `dout` is the inverse of `prog_d7` and bits 3 and 2 read 0. This holds even while an erase is suspended.
- R2: During the erase accept window (`op_erase`=1, `accept_win`=1), bit 7 and bit 3 read 0. While the embedded erase runs or has timed out outside that window, bit 7 reads 0 and bit 3 reads 1.
- R3: Bit 6 is a flop that inverts on each rising edge of `rd_stb` seen while a program, accept window or erase is active. In every other state it holds its value.
- R4: In the active states, bit 5 equals `tmo_fail`. `ready` is 0 whenever `busy` or `tmo_fail` is high, or an erase is in its accept window.
- R5: Bit 2 is a flop that inverts on each rising strobe edge during an accept window or an erase, and during a read of the suspended sector. A program does not move it.
- R6: When an erase is suspended and no program is running, a read whose top `SECT_W` address bits equal `susp_sect` returns bit 7 = 1, bit 6 = held value, bit 5 = 0, bit 3 = 0, bit 2 = flop value, with `ready` = 1.
- R7: When an erase is suspended, a read of any other sector returns `array_data` unchanged, with `ready` = 1.
- R8: With no operation active and no suspend, `dout` equals `array_data`, `ready` is 1, and strobes move neither flop.
- R9: Reset clears both polarity flops to 0. After reset, an idle read returns `array_data` with `ready` = 1.
- R10: A strobe held high for several cycles produces exactly one inversion.
- R11: Bits 4, 1 and 0 read 0 in every status state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_erase | input | 1 | Operation kind: 1 erase, 0 program |
| busy | input | 1 | Embedded operation in progress |
| tmo_fail | input | 1 | Operation exceeded its time limit |
| accept_win | input | 1 | Sector-erase accept window open |
| suspended | input | 1 | Erase is suspended |
| susp_sect | input | SECT_W | Sector number of the suspended or active erase |
| rd_addr | input | ADDR_W | Read address |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| rd_stb | input | 1 | Read strobe, level, synchronous to clk |
| array_data | input | 8 | Array contents at rd_addr |
| dout | output | 8 | Status byte or array data |
| ready | output | 1 | 1 when ready, 0 when busy or failed |

## Verification
The bench aims at the transitions between states. One case is a program started while an erase is suspended: if the priority order were wrong, that program would read back as suspend status with ready high. A read of the suspended sector must move bit 2 and leave bit 6 alone, so a design that toggled both would show a bit 6 change. A strobe is held high for several cycles; an edge detector that was missing or inverted would flip the flags on every cycle. After a mid-run reset, the bench checks that both flags return to a known 0, which a design that skipped clearing them would get wrong.

// File: rtl/status_pkg.sv
package status_pkg;
  typedef enum logic [2:0] {
    MD_ARRAY = 3'd0,
    MD_PROG  = 3'd1,
    MD_WIN   = 3'd2,
    MD_ERASE = 3'd3,
    MD_SUSP  = 3'd4
  } stat_mode_e;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned N_TOG  = 2;
  localparam int unsigned TOG_B6 = 0;
  localparam int unsigned TOG_B2 = 1;
endpackage

// File: rtl/sw_rise_det.sv
module sw_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic rise,
  output logic held
);
  logic held_d;

  always_comb begin
    held_d = stb;
    rise   = stb & ~held;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= held_d;
  end
endmodule

// File: rtl/sw_mode_dec.sv
module sw_mode_dec
  import status_pkg::*;
(
  input  logic       op_erase,
  input  logic       busy,
  input  logic       tmo_fail,
  input  logic       accept_win,
  input  logic       suspended,
  input  logic       sect_hit,
  output stat_mode_e mode,
  output logic [N_TOG-1:0] flip_en
);
  logic active;

  always_comb begin
    active = busy | tmo_fail;
    if (!op_erase && active)              mode = MD_PROG;
    else if (op_erase && accept_win)      mode = MD_WIN;
    else if (op_erase && active)          mode = MD_ERASE;
    else if (suspended && sect_hit)       mode = MD_SUSP;
    else                                  mode = MD_ARRAY;

    flip_en          = '0;
    flip_en[TOG_B6]  = (mode == MD_PROG) || (mode == MD_WIN) || (mode == MD_ERASE);
    flip_en[TOG_B2]  = (mode == MD_WIN) || (mode == MD_ERASE) || (mode == MD_SUSP);
  end
endmodule

// File: rtl/sw_toggles.sv
module sw_toggles
  import status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [N_TOG-1:0] flip_en,
  output logic [N_TOG-1:0] tog
);
  for (genvar g = 0; g < N_TOG; g++) begin : g_tog
    logic ce;
    logic nxt;

    always_comb begin
      ce  = rise & flip_en[g];
      nxt = ~tog[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tog[g] <= 1'b0;
      else if (ce) tog[g] <= nxt;
    end
  end
endmodule

// File: rtl/sw_word_mux.sv
module sw_word_mux
  import status_pkg::*;
(
  input  stat_mode_e        mode,
  input  logic              prog_d7,
  input  logic              tmo_fail,
  input  logic [N_TOG-1:0]  tog,
  input  logic [STAT_W-1:0] array_data,
  output logic [STAT_W-1:0] dout,
  output logic              ready
);
  always_comb begin
    dout  = '0;
    ready = 1'b1;
    unique case (mode)
      MD_PROG: begin
        dout[7] = ~prog_d7;
        dout[6] = tog[TOG_B6];
        dout[5] = tmo_fail;
        ready   = 1'b0;
      end
      MD_WIN: begin
        dout[6] = tog[TOG_B6];
        dout[5] = tmo_fail;
        dout[2] = tog[TOG_B2];
        ready   = 1'b0;
      end
      MD_ERASE: begin
        dout[6] = tog[TOG_B6];
        dout[5] = tmo_fail;
        dout[3] = 1'b1;
        dout[2] = tog[TOG_B2];
        ready   = 1'b0;
      end
      MD_SUSP: begin
        dout[7] = 1'b1;
        dout[6] = tog[TOG_B6];
        dout[2] = tog[TOG_B2];
      end
      default: dout = array_data;
    endcase
  end
endmodule

// File: rtl/status_word_gen.sv
module status_word_gen
  import status_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_erase,
  input  logic              busy,
  input  logic              tmo_fail,
  input  logic              accept_win,
  input  logic              suspended,
  input  logic [SECT_W-1:0] susp_sect,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              prog_d7,
  input  logic              rd_stb,
  input  logic [7:0]        array_data,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int unsigned SECT_LSB = ADDR_W - SECT_W;

  logic             rise;
  logic             stb_held;
  logic             sect_hit;
  stat_mode_e       mode;
  logic [N_TOG-1:0] flip_en;
  logic [N_TOG-1:0] tog;

  assign sect_hit = (rd_addr[ADDR_W-1:SECT_LSB] == susp_sect);

  sw_rise_det u_rise (
    .clk  (clk),
    .rst_n(rst_n),
    .stb  (rd_stb),
    .rise (rise),
    .held (stb_held)
  );

  sw_mode_dec u_dec (
    .op_erase  (op_erase),
    .busy      (busy),
    .tmo_fail  (tmo_fail),
    .accept_win(accept_win),
    .suspended (suspended),
    .sect_hit  (sect_hit),
    .mode      (mode),
    .flip_en   (flip_en)
  );

  sw_toggles u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise),
    .flip_en(flip_en),
    .tog    (tog)
  );

  sw_word_mux u_mux (
    .mode      (mode),
    .prog_d7   (prog_d7),
    .tmo_fail  (tmo_fail),
    .tog       (tog),
    .array_data(array_data),
    .dout      (dout),
    .ready     (ready)
  );
endmodule

// File: rtl/status_word_chk.sv
module status_word_chk #(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned SECT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_erase,
  input logic              busy,
  input logic              tmo_fail,
  input logic              accept_win,
  input logic              suspended,
  input logic [SECT_W-1:0] susp_sect,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              prog_d7,
  input logic              rd_stb,
  input logic              stb_held,
  input logic [1:0]        tog,
  input logic [7:0]        array_data,
  input logic [7:0]        dout,
  input logic              ready
);
  logic hit;
  logic act;
  assign hit = (rd_addr[ADDR_W-1 -: SECT_W] == susp_sect);
  assign act = busy | tmo_fail;

  AST_PROG_B7_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_erase && act) |-> (dout[7] == !prog_d7)); // R1

  AST_ERASE_B7_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (op_erase && (act || accept_win)) |-> !dout[7]); // R2

  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(tog)); // R3

  AST_BUSY_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (act || (op_erase && accept_win)) |-> !ready); // R4

  AST_SUSP_HIT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !act && !accept_win && hit) |-> (dout[7] && !dout[5] && ready)); // R6

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !accept_win && !suspended) |-> (dout == array_data && ready)); // R8

  AST_HELD_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && stb_held) |=> $stable(tog)); // R10

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (act || accept_win) |-> (dout[4] == 1'b0 && dout[1:0] == 2'b00)); // R11
endmodule

bind status_word_gen status_word_chk #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_erase  (op_erase),
  .busy      (busy),
  .tmo_fail  (tmo_fail),
  .accept_win(accept_win),
  .suspended (suspended),
  .susp_sect (susp_sect),
  .rd_addr   (rd_addr),
  .prog_d7   (prog_d7),
  .rd_stb    (rd_stb),
  .stb_held  (stb_held),
  .tog       (tog),
  .array_data(array_data),
  .dout      (dout),
  .ready     (ready)
);

// File: tb/sim_status_word_gen.sv
module sim_status_word_gen;
  localparam int ADDR_W = 18;
  localparam int SECT_W = 3;
  localparam int NV     = 18;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              op_erase, busy, tmo_fail, accept_win, suspended;
  logic [SECT_W-1:0] susp_sect;
  logic [ADDR_W-1:0] rd_addr;
  logic              prog_d7, rd_stb;
  logic [7:0]        array_data;
  logic [7:0]        dout;
  logic              ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  status_word_gen #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .op_erase(op_erase), .busy(busy),
    .tmo_fail(tmo_fail), .accept_win(accept_win), .suspended(suspended),
    .susp_sect(susp_sect), .rd_addr(rd_addr), .prog_d7(prog_d7),
    .rd_stb(rd_stb), .array_data(array_data), .dout(dout), .ready(ready)
  );

  // {erase,busy,tmo,win,susp,strobe,d7}, read sector, array byte, expected byte, expected ready
  localparam logic [26:0] VEC [NV] = '{
    {7'b0000010, 3'd0, 8'h5A, 8'h5A, 1'b1},
    {7'b0100011, 3'd0, 8'h5A, 8'h40, 1'b0},
    {7'b0100011, 3'd0, 8'h5A, 8'h00, 1'b0},
    {7'b0100010, 3'd0, 8'h5A, 8'hC0, 1'b0},
    {7'b0010010, 3'd0, 8'h5A, 8'hA0, 1'b0},
    {7'b0000010, 3'd0, 8'h5A, 8'h5A, 1'b1},
    {7'b1001010, 3'd0, 8'h5A, 8'h44, 1'b0},
    {7'b1001010, 3'd0, 8'h5A, 8'h00, 1'b0},
    {7'b1100010, 3'd0, 8'h5A, 8'h4C, 1'b0},
    {7'b1100000, 3'd0, 8'h5A, 8'h4C, 1'b0},
    {7'b1010010, 3'd0, 8'h5A, 8'h28, 1'b0},
    {7'b1000010, 3'd0, 8'hFF, 8'hFF, 1'b1},
    {7'b1000110, 3'd2, 8'h5A, 8'h84, 1'b1},
    {7'b1000110, 3'd2, 8'h5A, 8'h80, 1'b1},
    {7'b1000110, 3'd5, 8'h3C, 8'h3C, 1'b1},
    {7'b0100111, 3'd5, 8'h5A, 8'h40, 1'b0},
    {7'b0100111, 3'd2, 8'h5A, 8'h00, 1'b0},
    {7'b0000110, 3'd2, 8'h5A, 8'h84, 1'b1}
  };

  function automatic string vreq(int i);
    case (i)
      0, 5:          return "R8";
      1, 2, 3:       return "R1 R3 R11";
      4:             return "R4 R1";
      6, 7:          return "R2 R5 R3";
      8:             return "R2 R5";
      9:             return "R3 R5";
      10:            return "R4 R2";
      11:            return "R8";
      12, 13:        return "R6 R5";
      14:            return "R7";
      15, 16:        return "R1 R3";
      default:       return "R6 R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] exp_d, input logic exp_r);
    n_chk++;
    if (dout !== exp_d || ready !== exp_r) begin
      n_bad++;
      $display("FAIL %s: dout=%h ready=%b, expected dout=%h ready=%b",
               req, dout, ready, exp_d, exp_r);
    end
  endtask

  task automatic set_in(input logic [6:0] f, input logic [2:0] sect, input logic [7:0] arr);
    op_erase   = f[6];
    busy       = f[5];
    tmo_fail   = f[4];
    accept_win = f[3];
    suspended  = f[2];
    prog_d7    = f[0];
    rd_addr    = {sect, 15'h0123};
    array_data = arr;
  endtask

  task automatic strobe_read(input bit pulse);
    rd_stb = pulse;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic end_read();
    rd_stb = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    rd_stb = 1'b0;
    susp_sect = 3'd2;
    set_in(7'b0, 3'd0, 8'h5A);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset idle", 8'h5A, 1'b1);

    for (int i = 0; i < NV; i++) begin
      set_in(VEC[i][26:20], VEC[i][19:17], VEC[i][16:9]);
      strobe_read(VEC[i][21]);
      chk($sformatf("%s vec%0d", vreq(i), i), VEC[i][8:1], VEC[i][0]);
      end_read();
    end

    // R10: held strobe gives a single inversion (flags 0/1 -> 1/0)
    set_in(7'b1100000, 3'd0, 8'h5A);
    rd_stb = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 held strobe", 8'h48, 1'b0);
    end_read();
    strobe_read(1'b1);
    chk("R10 next strobe", 8'h0C, 1'b0);
    end_read();

    // R9: reset mid-run clears both flags
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 flags cleared", 8'h08, 1'b0);
    strobe_read(1'b1);
    chk("R9 first strobe after reset", 8'h4C, 1'b0);
    end_read();

    // R8: strobes while idle leave the flags alone; visible at the next erase read
    set_in(7'b0, 3'd0, 8'hA5);
    strobe_read(1'b1);
    chk("R8 idle strobe", 8'hA5, 1'b1);
    end_read();
    set_in(7'b1100000, 3'd0, 8'h5A);
    strobe_read(1'b0);
    chk("R8 flags unchanged by idle strobe", 8'h4C, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all requirements): run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule